// File: doc/BRIEF.md
# Codec Control Slot Register File

This block sits behind the serial-port shifter of one voice codec in a cascade. Whenever a complete 16-bit control slot has been shifted in, the shifter presents the word together with a strobe. The block decodes the word and updates one of six 8-bit control registers. For a read, it prepares a 16-bit reply that the shifter sends back in the same control slot. Each device owns a 4-bit cascade address, and every reply carries that address.

A write may be marked for the whole cascade. Every device sees that word through a separate broadcast-in indication and stores the byte as if the write had been addressed to it. Two sticky flags in control register 1 record converter overflow events. Reading that register reports the flags and then clears them. Control register 4 holds the divider parameters M, N and P. Its contents, along with the other registers, are driven straight out to the clock generator and the slot sequencer.

Top module: `ctlreg_file`

## Requirements
- R1: A control word has this layout:
  - bits 15..13 are the register address, and values 1 to 6 select CR1 to CR6;
  - bit 12 is 1 for a read and 0 for a write;
  - bit 11 is the broadcast bit;
  - bits 10..8 must be 111;
  - bits 7..0 are the write data.
  A word with address 0 or 7, or with bits 10..8 other than 111, changes no register and gives no reply.
- R2: When `ctl_strobe` is high, a write stores bits 7..0 in the addressed register. The new value is visible on the register outputs one clock later.
- R3: When `bcast_in` is high and `ctl_strobe` is low, a write is applied only if bit 11 is set. A read that has bit 11 set is ignored: there is no reply and no flag is cleared.
- R4: A read raises `rsp_valid` for exactly the one cycle that follows the strobe. In that cycle `rsp_word` is {dev_addr[3:0], address[2:0], 1'b0, contents[7:0]}.
- R5: A pulse on `adc_ovf_evt` sets CR1 bit 7, and a pulse on `dac_ovf_evt` sets CR1 bit 4. Each flag stays set until CR1 is read.
- R6: A read of CR1 reports the flags before they are cleared and clears both of them one cycle later. Writes to CR1 do not change bits 7 and 4.
- R7: An overflow event in the same cycle as a CR1 read leaves that flag set.
- R8: A CR4 write changes different fields depending on its bit 7:
  - with bit 7 set, bits 6..0 load M;
  - with bit 7 clear, bits 6..3 load N and bits 2..0 load P (code 000 means 8).
  A CR4 read returns the form that was last written: {1, M} or {0, N, P}.
- R9: Reset gives the following values:
  - M = 16;
  - N = 6;
  - P code = 000, which means 8;
  - CR4 read form = N/P;
  - every other register = 00;
  - both flags cleared;
  - `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_addr | input | 4 | Cascade address of this device |
| ctl_strobe | input | 1 | Control word belongs to this device's slot |
| bcast_in | input | 1 | Control word from another device's slot |
| ctl_word | input | 16 | Received control word |
| adc_ovf_evt | input | 1 | ADC overflow pulse |
| dac_ovf_evt | input | 1 | DAC overflow pulse |
| rsp_valid | output | 1 | Reply word valid |
| rsp_word | output | 16 | Reply word for the DOUT control slot |
| cr1_q | output | 8 | CR1 contents, flags included |
| cr2_q | output | 8 | CR2 contents |
| cr3_q | output | 8 | CR3 contents |
| cr5_q | output | 8 | CR5 contents |
| cr6_q | output | 8 | CR6 contents |
| m_val | output | 7 | Divider M |
| n_val | output | 4 | Divider N |
| p_code | output | 3 | Divider P code (000 means 8) |

## Verification
The assertions check four things on every cycle:
- an overflow event always leaves its flag set one cycle later;
- a set flag only clears after a CR1 read;
- a reply appears only after a read strobe and carries the device address with bit 8 at zero;
- a malformed word never changes a register.

Only the bench scenarios can show the rest:
- the data path for each register;
- broadcast acceptance and rejection;
- the two CR4 write forms and how a CR4 read reflects them;
- the reset defaults;
- the case where an event coincides with a clearing read.

// File: rtl/ctlreg_file.sv
module ctlreg_file #(
  parameter int           DEV_W  = 4,
  parameter logic [6:0]   M_RST  = 7'd16,
  parameter logic [3:0]   N_RST  = 4'd6,
  parameter logic [2:0]   P_RST  = 3'd0,
  parameter logic [7:0]   CR_RST = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEV_W-1:0] dev_addr,
  input  logic             ctl_strobe,
  input  logic             bcast_in,
  input  logic [15:0]      ctl_word,
  input  logic             adc_ovf_evt,
  input  logic             dac_ovf_evt,
  output logic             rsp_valid,
  output logic [15:0]      rsp_word,
  output logic [7:0]       cr1_q,
  output logic [7:0]       cr2_q,
  output logic [7:0]       cr3_q,
  output logic [7:0]       cr5_q,
  output logic [7:0]       cr6_q,
  output logic [6:0]       m_val,
  output logic [3:0]       n_val,
  output logic [2:0]       p_code
);
  logic [2:0] ra;
  logic       is_rd, is_bc, fmt_ok, do_wr, do_rd, rd_cr1;
  logic [7:0] wdat, cr1_rw, cr4_rd, rdat;
  logic       adc_ovf, dac_ovf, cr4_sel;

  assign ra     = ctl_word[15:13];
  assign is_rd  = ctl_word[12];
  assign is_bc  = ctl_word[11];
  assign wdat   = ctl_word[7:0];
  assign fmt_ok = (ctl_word[10:8] == 3'b111) && (ra != 3'd0) && (ra != 3'd7);
  assign do_wr  = fmt_ok && !is_rd && (ctl_strobe || (bcast_in && is_bc));
  assign do_rd  = fmt_ok && is_rd && !is_bc && ctl_strobe;
  assign rd_cr1 = do_rd && (ra == 3'd1);

  assign cr1_q  = {adc_ovf, cr1_rw[6:5], dac_ovf, cr1_rw[3:0]};
  assign cr4_rd = cr4_sel ? {1'b1, m_val} : {1'b0, n_val, p_code};

  always_comb begin
    case (ra)
      3'd1:    rdat = cr1_q;
      3'd2:    rdat = cr2_q;
      3'd3:    rdat = cr3_q;
      3'd4:    rdat = cr4_rd;
      3'd5:    rdat = cr5_q;
      3'd6:    rdat = cr6_q;
      default: rdat = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr1_rw <= CR_RST; cr2_q <= CR_RST; cr3_q <= CR_RST;
      cr5_q  <= CR_RST; cr6_q <= CR_RST;
      m_val <= M_RST; n_val <= N_RST; p_code <= P_RST; cr4_sel <= 1'b0;
      adc_ovf <= 1'b0; dac_ovf <= 1'b0;
      rsp_valid <= 1'b0; rsp_word <= 16'h0000;
    end else begin
      adc_ovf   <= adc_ovf_evt || (adc_ovf && !rd_cr1);
      dac_ovf   <= dac_ovf_evt || (dac_ovf && !rd_cr1);
      rsp_valid <= do_rd;
      if (do_rd) rsp_word <= {dev_addr, ra, 1'b0, rdat};
      if (do_wr) begin
        case (ra)
          3'd1: cr1_rw <= wdat;
          3'd2: cr2_q  <= wdat;
          3'd3: cr3_q  <= wdat;
          3'd4: begin
            cr4_sel <= wdat[7];
            if (wdat[7]) m_val <= wdat[6:0];
            else begin n_val <= wdat[6:3]; p_code <= wdat[2:0]; end
          end
          3'd5: cr5_q  <= wdat;
          3'd6: cr6_q  <= wdat;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctlreg_file_chk.sv
module ctlreg_file_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  dev_addr,
  input logic        ctl_strobe,
  input logic        bcast_in,
  input logic [15:0] ctl_word,
  input logic        adc_ovf_evt,
  input logic        dac_ovf_evt,
  input logic        rsp_valid,
  input logic [15:0] rsp_word,
  input logic [7:0]  cr1_q,
  input logic [7:0]  cr2_q,
  input logic [7:0]  cr3_q,
  input logic [7:0]  cr5_q,
  input logic [7:0]  cr6_q,
  input logic [6:0]  m_val,
  input logic [3:0]  n_val,
  input logic [2:0]  p_code
);
  logic cr1_read, bad_fmt;
  assign cr1_read = ctl_strobe && (ctl_word[15:11] == 5'b00110) && (ctl_word[10:8] == 3'b111);
  assign bad_fmt  = (ctl_strobe || bcast_in) && (ctl_word[10:8] != 3'b111);

  assert_adc_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_ovf_evt |=> cr1_q[7]);
  assert_dac_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dac_ovf_evt |=> cr1_q[4]);
  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cr1_q[7] && !cr1_read) |=> cr1_q[7]);
  assert_rsp_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(ctl_strobe && ctl_word[12]));
  assert_rsp_header_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_word[15:12] == $past(dev_addr) && !rsp_word[8]));
  assert_bad_word_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bad_fmt |=> ($stable(cr2_q) && $stable(cr3_q) && $stable(cr5_q) && $stable(cr6_q)
                 && $stable(m_val) && $stable(n_val) && $stable(p_code) && !rsp_valid));
endmodule

bind ctlreg_file ctlreg_file_chk u_chk (.*);

// File: tb/ctlreg_file_bench.sv
module ctlreg_file_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [3:0] DEV = 4'h9;

  logic clk = 0, rst_n = 0, ctl_strobe = 0, bcast_in = 0, adc_ovf_evt = 0, dac_ovf_evt = 0;
  logic [15:0] ctl_word = 16'h0;
  logic rsp_valid;
  logic [15:0] rsp_word;
  logic [7:0] cr1_q, cr2_q, cr3_q, cr5_q, cr6_q;
  logic [6:0] m_val;
  logic [3:0] n_val;
  logic [2:0] p_code;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlreg_file u_ctlreg_file (
    .clk, .rst_n, .dev_addr(DEV), .ctl_strobe, .bcast_in, .ctl_word,
    .adc_ovf_evt, .dac_ovf_evt, .rsp_valid, .rsp_word,
    .cr1_q, .cr2_q, .cr3_q, .cr5_q, .cr6_q, .m_val, .n_val, .p_code);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wr(logic [2:0] a, logic bc, logic [7:0] d);
    return {a, 1'b0, bc, 3'b111, d};
  endfunction
  function automatic logic [15:0] rd(logic [2:0] a);
    return {a, 1'b1, 1'b0, 3'b111, 8'h00};
  endfunction

  task automatic send(logic [15:0] w, logic s, logic b);
    @(negedge clk);
    ctl_word = w; ctl_strobe = s; bcast_in = b;
    @(negedge clk);
    ctl_strobe = 0; bcast_in = 0;
  endtask

  task automatic t_reset;
    chk("R9 m", m_val, 16); chk("R9 n", n_val, 6); chk("R9 p", p_code, 0);
    chk("R9 cr1", cr1_q, 0); chk("R9 cr2", cr2_q, 0); chk("R9 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_write_read;
    send(wr(3'd2, 0, 8'hA5), 1, 0);
    chk("R2 cr2", cr2_q, 8'hA5);
    chk("R4 no reply to write", rsp_valid, 0);
    send(rd(3'd2), 1, 0);
    chk("R4 valid", rsp_valid, 1);
    chk("R4 word", rsp_word, {DEV, 3'd2, 1'b0, 8'hA5});
    @(negedge clk);
    chk("R4 one cycle", rsp_valid, 0);
    send(wr(3'd6, 0, 8'h3C), 1, 0);
    chk("R2 cr6", cr6_q, 8'h3C);
  endtask

  task automatic t_broadcast;
    send(wr(3'd3, 1, 8'h5A), 0, 1);
    chk("R3 bcast write", cr3_q, 8'h5A);
    send(wr(3'd3, 0, 8'h11), 0, 1);
    chk("R3 non-bcast ignored", cr3_q, 8'h5A);
    send({3'd2, 1'b1, 1'b1, 3'b111, 8'h00}, 1, 0);
    chk("R3 bcast read ignored", rsp_valid, 0);
  endtask

  task automatic t_malformed;
    send({3'd5, 1'b0, 1'b0, 3'b110, 8'hFF}, 1, 0);
    chk("R1 bad marker", cr5_q, 0);
    send(wr(3'd0, 0, 8'hFF), 1, 0);
    chk("R1 addr0 cr2", cr2_q, 8'hA5);
    send(wr(3'd7, 0, 8'hFF), 1, 0);
    chk("R1 addr7 cr6", cr6_q, 8'h3C);
    send({3'd2, 1'b1, 1'b0, 3'b011, 8'h00}, 1, 0);
    chk("R1 bad read no reply", rsp_valid, 0);
  endtask

  task automatic t_cr4;
    send(wr(3'd4, 0, 8'h94), 1, 0);
    chk("R8 m", m_val, 20); chk("R8 n kept", n_val, 6); chk("R8 p kept", p_code, 0);
    send(rd(3'd4), 1, 0);
    chk("R8 read m form", rsp_word[7:0], 8'h94);
    send(wr(3'd4, 0, 8'h2A), 1, 0);
    chk("R8 n", n_val, 5); chk("R8 p", p_code, 2); chk("R8 m kept", m_val, 20);
    send(rd(3'd4), 1, 0);
    chk("R8 read np form", rsp_word[7:0], 8'h2A);
  endtask

  task automatic t_flags;
    @(negedge clk); adc_ovf_evt = 1; @(negedge clk); adc_ovf_evt = 0;
    chk("R5 adc set", cr1_q[7], 1);
    repeat (3) @(negedge clk);
    chk("R5 adc sticky", cr1_q[7], 1);
    send(wr(3'd1, 0, 8'hFF), 1, 0);
    chk("R6 write skips flags", cr1_q, 8'hEF);
    send(rd(3'd1), 1, 0);
    chk("R6 reply has flag", rsp_word[7:0], 8'hEF);
    chk("R6 cleared", cr1_q, 8'h6F);
    @(negedge clk); dac_ovf_evt = 1; @(negedge clk); dac_ovf_evt = 0;
    chk("R5 dac set", cr1_q[4], 1);
    @(negedge clk);
    ctl_word = rd(3'd1); ctl_strobe = 1; dac_ovf_evt = 1;
    @(negedge clk);
    ctl_strobe = 0; dac_ovf_evt = 0;
    chk("R7 flag kept", cr1_q[4], 1);
    send(rd(3'd1), 1, 0);
    chk("R6 cleared after", cr1_q[4], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_write_read; t_broadcast; t_malformed; t_cr4; t_flags;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule